// File: doc/BRIEF.md
# Firmware Hub Cycle Preamble Decoder

This block is the target-side front end of a 4-bit multiplexed firmware-hub bus. On every bus clock it samples a nibble-wide data bus and an active-low frame strobe. It finds the one-clock start field that opens a cycle and sorts the cycle into a memory read, a memory write, or a cycle of some other kind. For reads and writes it then checks the device-select nibble against a strapped local ID, assembles a 28-bit address from seven nibbles and captures the size nibble.

When the whole preamble has been parsed for this device, the block hands downstream logic a one-clock request pulse. The pulse carries the direction, the address, the size and a flag that says whether the size can be served. A start code it does not own gives a one-clock foreign-cycle indication instead, and the block does not claim the bus. Either a reset or an init input stops any decode in progress. The turnaround, sync and data phases are handled elsewhere.

Top module: `fwh_preamble_decoder`

## Requirements
- R1: While `rst_n` is low, and on the clock after it is sampled low, `req_valid` and `foreign_cycle` are 0 and `req_write`, `req_addr`, `req_size` and `req_size_ok` are all zero.
- R2: The start code is taken from the last clock on which `frame_n` is sampled low. Each earlier low clock's nibble is replaced by the nibble of the next low clock.
- R3: Start code 4'b1101 decodes as a read and 4'b1110 as a write. `req_write` is 0 for a read and 1 for a write, and it is loaded on the device-select clock.
- R4: Any other start code raises `foreign_cycle` for exactly one clock, after the edge at which the first high `frame_n` is sampled. No request is issued for that cycle.
- R5: The nibble on the first clock after the start field is the device select. If it differs from `local_id`, the block issues no request, ignores the bus until `frame_n` is low again, and leaves `req_write` and `req_addr` unchanged.
- R6: The seven nibbles after a matching device select form `req_addr`, with the most significant nibble first. Each nibble shifts into bits [3:0], and the register is cleared on the device-select clock.
- R7: The nibble after the seventh address nibble is loaded into `req_size`. `req_size_ok` is 1 only when that nibble is 0.
- R8: `req_valid` is high for exactly one clock, after the edge that samples the size nibble. It is high only if that decode ran to completion.
- R9: If `frame_n` is sampled low during the device-select, address or size clocks, the current decode is dropped and that clock is treated as a new start field. In that case no request or foreign indication follows on the next clock.
- R10: Sampling `init_n` low aborts decoding exactly as reset does and clears every output. A cycle that `init_n` interrupted never produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_n | input | 1 | Active-low initialisation; aborts decoding like reset |
| frame_n | input | 1 | Active-low cycle frame strobe |
| bus_nib | input | 4 | Multiplexed data nibble |
| local_id | input | 4 | Strapped device-select value |
| req_valid | output | 1 | One-clock request pulse |
| req_write | output | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | output | 28 | Assembled address |
| req_size | output | 4 | Captured size nibble |
| req_size_ok | output | 1 | Size is a single byte (nibble 0) |
| foreign_cycle | output | 1 | One-clock pulse for a start code this block does not own |

## Verification
The embedded properties check, on every clock, the behaviour that follows from local state. A request pulse lasts one clock and comes only out of the size phase. A foreign pulse and a request never coincide, and a foreign pulse follows only a non-owned start code. A low frame strobe, a reset or an init leaves no pulse on the next clock, and a device-select mismatch leads straight back to idle. Other behaviour spans a whole cycle, and only the bench scenarios can show it. These include which of several low-strobe clocks supplies the start code, the nibble order of the assembled address, size acceptance, and a clean restart after an interrupted decode.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SIZE
  } fwh_phase_e;

  typedef enum logic [1:0] {
    KIND_READ,
    KIND_WRITE,
    KIND_FOREIGN
  } fwh_kind_e;

  // Sort a start nibble into read, write or foreign.
  function automatic fwh_kind_e classify_start(
    input logic [NIB_W-1:0] code,
    input logic [NIB_W-1:0] rd_code,
    input logic [NIB_W-1:0] wr_code
  );
    if (code == rd_code)      return KIND_READ;
    else if (code == wr_code) return KIND_WRITE;
    else                      return KIND_FOREIGN;
  endfunction

  // Only a size nibble of zero (one byte) is served.
  function automatic logic size_is_single(input logic [NIB_W-1:0] sz);
    return (sz == '0);
  endfunction

endpackage

// File: rtl/fwh_start_capture.sv
module fwh_start_capture
  import fwh_pkg::*;
(
  input  logic             clk,
  input  logic             abort,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  output logic             armed,
  output logic [NIB_W-1:0] code
);

  // armed: the previous clock had the strobe low, so code holds the
  // newest start candidate. A run of low clocks keeps overwriting it.
  always_ff @(posedge clk) begin
    if (abort) begin
      armed <= 1'b0;
      code  <= '0;
    end else begin
      armed <= ~frame_n;
      if (!frame_n) code <= nib;
    end
  end

endmodule

// File: rtl/fwh_addr_shift.sv
module fwh_addr_shift
  import fwh_pkg::*;
#(
  parameter int NIBS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic                  clr,
  input  logic                  shift_en,
  input  logic [NIB_W-1:0]      nib,
  output logic [NIB_W*NIBS-1:0] addr,
  output logic                  last
);

  localparam int ADDR_W = NIB_W * NIBS;
  localparam int CNT_W  = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NIBS - 1);

  logic [CNT_W-1:0] cnt;

  assign last = shift_en && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (abort || clr) begin
      addr <= '0;
      cnt  <= '0;
    end else if (shift_en) begin
      addr <= {addr[ADDR_W-NIB_W-1:0], nib};
      cnt  <= last ? '0 : cnt + 1'b1;
    end
  end

  // R6: the nibble counter never runs past the last address nibble
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST);

endmodule

// File: rtl/fwh_preamble_fsm.sv
module fwh_preamble_fsm
  import fwh_pkg::*;
#(
  parameter logic [NIB_W-1:0] RD_CODE = 4'b1101,
  parameter logic [NIB_W-1:0] WR_CODE = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  input  logic [NIB_W-1:0] local_id,
  input  logic             armed,
  input  logic [NIB_W-1:0] code,
  input  logic             addr_last,
  output logic             addr_clr,
  output logic             addr_shift,
  output logic             req_valid,
  output logic             req_write,
  output logic [NIB_W-1:0] req_size,
  output logic             req_size_ok,
  output logic             foreign_cycle
);

  fwh_phase_e state, state_nx;
  fwh_kind_e  kind;

  // Named events for the properties and the datapath.
  logic start_done;  // start field closed; this clock carries the device select
  logic owned;       // closed start code is a read or a write
  logic id_hit;      // device select matches the local strap
  logic take_cycle;  // owned and selected: address phase follows
  logic size_clk;    // this clock carries the size nibble

  assign kind       = classify_start(code, RD_CODE, WR_CODE);
  assign start_done = armed && frame_n;
  assign owned      = (kind != KIND_FOREIGN);
  assign id_hit     = (nib == local_id);
  assign take_cycle = start_done && owned && id_hit;
  assign size_clk   = frame_n && (state == PH_SIZE);
  assign addr_clr   = take_cycle;
  assign addr_shift = frame_n && (state == PH_ADDR);

  always_comb begin
    state_nx = state;
    if (!frame_n) begin
      state_nx = PH_IDLE;
    end else if (take_cycle) begin
      state_nx = PH_ADDR;
    end else begin
      case (state)
        PH_ADDR: if (addr_last) state_nx = PH_SIZE;
        PH_SIZE: state_nx = PH_IDLE;
        default: state_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (abort) begin
      state         <= PH_IDLE;
      req_valid     <= 1'b0;
      req_write     <= 1'b0;
      req_size      <= '0;
      req_size_ok   <= 1'b0;
      foreign_cycle <= 1'b0;
    end else begin
      state         <= state_nx;
      req_valid     <= size_clk;
      foreign_cycle <= start_done && !owned;
      if (take_cycle) req_write <= (kind == KIND_WRITE);
      if (size_clk) begin
        req_size    <= nib;
        req_size_ok <= size_is_single(nib);
      end
    end
  end

  // R8: a request lasts one clock
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R7: a request only follows a size clock
  assert_valid_from_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(state) == PH_SIZE);

  // R4: foreign indication and request never coincide
  assert_foreign_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(foreign_cycle && req_valid));

  // R4: foreign only after a start code that is neither read nor write
  assert_foreign_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_cycle |-> ($past(code) != RD_CODE && $past(code) != WR_CODE));

  // R5: a device-select mismatch returns to idle
  assert_mismatch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n || abort)
    (start_done && owned && !id_hit) |=> state == PH_IDLE);

  // R1/R10: abort leaves the decoder idle and silent
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == PH_IDLE && !req_valid && !foreign_cycle));

endmodule

// File: rtl/fwh_preamble_decoder.sv
module fwh_preamble_decoder
  import fwh_pkg::*;
#(
  parameter int               ADDR_NIBS = 7,
  parameter logic [NIB_W-1:0] RD_CODE   = 4'b1101,
  parameter logic [NIB_W-1:0] WR_CODE   = 4'b1110
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init_n,
  input  logic                       frame_n,
  input  logic [NIB_W-1:0]           bus_nib,
  input  logic [NIB_W-1:0]           local_id,
  output logic                       req_valid,
  output logic                       req_write,
  output logic [NIB_W*ADDR_NIBS-1:0] req_addr,
  output logic [NIB_W-1:0]           req_size,
  output logic                       req_size_ok,
  output logic                       foreign_cycle
);

  logic             abort;
  logic             armed;
  logic [NIB_W-1:0] code;
  logic             addr_clr;
  logic             addr_shift;
  logic             addr_last;

  assign abort = !rst_n || !init_n;

  fwh_start_capture u_start (
    .clk     (clk),
    .abort   (abort),
    .frame_n (frame_n),
    .nib     (bus_nib),
    .armed   (armed),
    .code    (code)
  );

  fwh_preamble_fsm #(
    .RD_CODE (RD_CODE),
    .WR_CODE (WR_CODE)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort         (abort),
    .frame_n       (frame_n),
    .nib           (bus_nib),
    .local_id      (local_id),
    .armed         (armed),
    .code          (code),
    .addr_last     (addr_last),
    .addr_clr      (addr_clr),
    .addr_shift    (addr_shift),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_size      (req_size),
    .req_size_ok   (req_size_ok),
    .foreign_cycle (foreign_cycle)
  );

  fwh_addr_shift #(
    .NIBS (ADDR_NIBS)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .clr      (addr_clr),
    .shift_en (addr_shift),
    .nib      (bus_nib),
    .addr     (req_addr),
    .last     (addr_last)
  );

  // R9: a low strobe always restarts, so no pulse on the next clock
  assert_frame_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (!req_valid && !foreign_cycle));

  // R1: reset clears the request outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!req_valid && !foreign_cycle && req_addr == '0 && !req_write));

endmodule

// File: tb/fwh_preamble_decoder_tb.sv
module fwh_preamble_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_n = 1'b1;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_nib = 4'h0;
  logic [3:0]  local_id = 4'h5;
  logic        req_valid, req_write, req_size_ok, foreign_cycle;
  logic [27:0] req_addr;
  logic [3:0]  req_size;

  always #2 clk = ~clk;

  fwh_preamble_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .frame_n(frame_n),
    .bus_nib(bus_nib), .local_id(local_id), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_size_ok(req_size_ok), .foreign_cycle(foreign_cycle)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // Behavioural reference: phase -1 idle, 0 start seen, 1..7 address, 8 size
  int          ph = -1;
  int          st_code = 0;
  bit          e_valid = 0, e_write = 0, e_ok = 0, e_foreign = 0;
  logic [27:0] e_addr = '0;
  logic [3:0]  e_size = '0;

  always @(posedge clk) begin
    e_valid   = 0;
    e_foreign = 0;
    if (!rst_n || !init_n) begin
      ph = -1; st_code = 0; e_write = 0; e_addr = '0; e_size = '0; e_ok = 0;
    end else if (!frame_n) begin
      ph = 0; st_code = int'(bus_nib);
    end else if (ph == 0) begin
      if (st_code == 13 || st_code == 14) begin
        if (bus_nib == local_id) begin
          ph = 1; e_write = (st_code == 14); e_addr = '0;
        end else ph = -1;
      end else begin
        e_foreign = 1; ph = -1;
      end
    end else if (ph >= 1 && ph <= 7) begin
      e_addr = e_addr * 16 + 28'(bus_nib);
      ph = ph + 1;
    end else if (ph == 8) begin
      e_size = bus_nib; e_ok = (bus_nib == 0); e_valid = 1; ph = -1;
    end
  end

  // Observed pulses for directed checks
  int          seen_valid = 0, seen_foreign = 0;
  logic [27:0] seen_addr;
  logic        seen_write, seen_ok;
  logic [3:0]  seen_size;

  always @(negedge clk) begin
    if (cmp_on) begin
      n_cmp++;
      if (req_valid !== e_valid || foreign_cycle !== e_foreign || req_write !== e_write ||
          req_addr !== e_addr || req_size !== e_size || req_size_ok !== e_ok) begin
        n_bad++;
        $display("FAIL %s: got v=%b f=%b w=%b a=%h s=%h ok=%b exp v=%b f=%b w=%b a=%h s=%h ok=%b",
          cur_req, req_valid, foreign_cycle, req_write, req_addr, req_size, req_size_ok,
          e_valid, e_foreign, e_write, e_addr, e_size, e_ok);
      end
      if (req_valid === 1'b1) begin
        seen_valid++; seen_addr = req_addr; seen_write = req_write;
        seen_size = req_size; seen_ok = req_size_ok;
      end
      if (foreign_cycle === 1'b1) seen_foreign++;
    end
  end

  task automatic check(input string tag, input bit ok_cond, input string got, input string exp);
    n_cmp++;
    if (!ok_cond) begin
      n_bad++;
      $display("FAIL %s: got %s exp %s", tag, got, exp);
    end
  endtask

  task automatic drv(input logic fr, input logic [3:0] n);
    @(negedge clk);
    frame_n = fr;
    bus_nib = n;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) drv(1'b1, 4'hF);
  endtask

  // Full preamble: start code(s), device select, 7 address nibbles, size
  task automatic preamble(input logic [3:0] c, input logic [3:0] id,
                          input logic [27:0] a, input logic [3:0] sz);
    drv(1'b0, c);
    drv(1'b1, id);
    for (int i = 6; i >= 0; i--) drv(1'b1, a[i*4 +: 4]);
    drv(1'b1, sz);
  endtask

  task automatic clear_seen();
    seen_valid = 0; seen_foreign = 0;
  endtask

  task automatic expect_req(input string tag, input logic w, input logic [27:0] a,
                            input logic [3:0] sz, input logic ok);
    idle(3);
    check(tag, seen_valid == 1, $sformatf("%0d pulses", seen_valid), "1 pulse");
    check(tag, seen_write === w && seen_addr === a && seen_size === sz && seen_ok === ok,
      $sformatf("w=%b a=%h s=%h ok=%b", seen_write, seen_addr, seen_size, seen_ok),
      $sformatf("w=%b a=%h s=%h ok=%b", w, a, sz, ok));
    clear_seen();
  endtask

  task automatic expect_none(input string tag, input int fcount);
    idle(3);
    check(tag, seen_valid == 0, $sformatf("%0d req pulses", seen_valid), "0");
    check(tag, seen_foreign == fcount, $sformatf("%0d foreign", seen_foreign),
      $sformatf("%0d", fcount));
    clear_seen();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1", req_valid === 0 && foreign_cycle === 0 && req_addr === '0 && req_write === 0
      && req_size === '0 && req_size_ok === 0,
      $sformatf("v=%b f=%b a=%h", req_valid, foreign_cycle, req_addr), "all zero");
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(2);

    // R3/R6/R8: read, address order
    cur_req = "R3_R6_R8";
    preamble(4'b1101, 4'h5, 28'h1234567, 4'h0);
    expect_req("R3 read / R6 addr / R8 pulse", 1'b0, 28'h1234567, 4'h0, 1'b1);

    // R2: several low clocks, last one is the write code
    cur_req = "R2";
    drv(1'b0, 4'h3);
    drv(1'b0, 4'h0);
    preamble(4'b1110, 4'h5, 28'hABCDEF0, 4'h0);
    expect_req("R2 last-low start / R3 write", 1'b1, 28'hABCDEF0, 4'h0, 1'b1);

    // R2: owned code replaced by a foreign one
    drv(1'b0, 4'b1101);
    preamble(4'b0000, 4'h5, 28'h1111111, 4'h0);
    expect_none("R2 replaced by foreign", 1);

    // R7: unsupported size
    cur_req = "R7";
    preamble(4'b1101, 4'h5, 28'h0FEDCBA, 4'h5);
    expect_req("R7 size 5", 1'b0, 28'h0FEDCBA, 4'h5, 1'b0);

    // R4: foreign start code
    cur_req = "R4";
    preamble(4'b0010, 4'h5, 28'h2222222, 4'h0);
    expect_none("R4 foreign", 1);

    // R5: device-select mismatch, rest ignored; outputs keep the last request
    cur_req = "R5";
    preamble(4'b1110, 4'h6, 28'h3333333, 4'h0);
    expect_none("R5 mismatch", 0);
    check("R5 addr untouched", req_addr === 28'h0FEDCBA && req_write === 1'b0,
      $sformatf("a=%h w=%b", req_addr, req_write), "a=0fedcba w=0");

    // R9: frame low mid-address restarts with a new start field
    cur_req = "R9";
    drv(1'b0, 4'b1101);
    drv(1'b1, 4'h5);
    drv(1'b1, 4'h9);
    drv(1'b1, 4'h9);
    preamble(4'b1110, 4'h5, 28'h7654321, 4'h0);
    expect_req("R9 restart", 1'b1, 28'h7654321, 4'h0, 1'b1);

    // R9: frame low on the size clock
    drv(1'b0, 4'b1101);
    drv(1'b1, 4'h5);
    for (int i = 0; i < 7; i++) drv(1'b1, 4'h8);
    drv(1'b0, 4'h0);
    idle(1);
    expect_none("R9 low on size clock", 1);

    // R10: init mid-address aborts and clears
    cur_req = "R10";
    drv(1'b0, 4'b1101);
    drv(1'b1, 4'h5);
    drv(1'b1, 4'h4);
    @(negedge clk); init_n = 1'b0; frame_n = 1'b1; bus_nib = 4'h4;
    @(negedge clk); init_n = 1'b1;
    check("R10 cleared", req_addr === '0 && req_valid === 0,
      $sformatf("a=%h v=%b", req_addr, req_valid), "a=0 v=0");
    idle(8);
    expect_none("R10 abort", 0);
    preamble(4'b1101, 4'h5, 28'h5A5A5A5, 4'h0);
    expect_req("R10 recovery", 1'b0, 28'h5A5A5A5, 4'h0, 1'b1);

    // R1: reset mid-cycle
    cur_req = "R1";
    drv(1'b0, 4'b1110);
    drv(1'b1, 4'h5);
    @(negedge clk); rst_n = 1'b0; bus_nib = 4'h1;
    @(negedge clk); rst_n = 1'b1;
    check("R1 mid-cycle reset", req_addr === '0 && req_write === 0 && req_size === '0,
      $sformatf("a=%h w=%b", req_addr, req_write), "zero");
    idle(10);
    expect_none("R1 no request after reset", 0);

    done = 1'b1;
    finish_run();
  end

endmodule